// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block holds the event counters of one Ethernet MAC port. Each counter is 40 bits wide. Every counter has a single-cycle strobe input. Two of the counters, received octets and transmitted octets, add a byte count that comes with the strobe; all the others add one. Software takes a consistent view of the whole bank by writing a snapshot command. At that clock edge every live counter is copied into its own shadow register. Software then reads the shadow registers at its own pace through a 16-bit register port, while the live counters keep counting.

A 40-bit counter can wrap during a long run. When a counter wraps, it sets its own flag in a 64-bit rollover vector. Software reads this vector as four 16-bit words, and reading a word clears it. Software adds 2^40 to its own copy of a counter each time it finds that counter's flag set, which extends the count past 40 bits.

A small bus state machine sequences the register port. It has three states:
- `ST_IDLE`: accepts requests.
- `ST_READ_OUT`: presents read data for one cycle.
- `ST_SNAP_HOLD`: a one-cycle rest after a snapshot.

Its transitions are:
- read accepted: `ST_IDLE`→`ST_READ_OUT`
- snapshot accepted: `ST_IDLE`→`ST_SNAP_HOLD`
- no accepted request: `ST_IDLE`→`ST_IDLE`
- always after one cycle: `ST_READ_OUT`→`ST_IDLE` and `ST_SNAP_HOLD`→`ST_IDLE`

With the default parameters the counters are indexed as follows:

| Index | Counter |
|---|---|
| 0 | receive octets |
| 1 | receive unicast |
| 2 | receive multicast |
| 3 | receive broadcast |
| 4 | receive pause |
| 5 | receive FCS errors |
| 6 | receive internal MAC errors |
| 7 | receive symbol errors |
| 8 | receive length errors |
| 9 | receive too-long frames |
| 10 | receive jabbers |
| 11 | receive fragments |
| 12 | receive undersized |
| 13 | transmit octets |
| 14 | transmit internal errors |
| 15 | transmit system errors |
| 16 | transmit unicast |
| 17 | transmit multicast |
| 18 | transmit broadcast |
| 19 | transmit pause |

Top module: `stat_snapshot_bank`

## Requirements
- R1: After reset, all live counters, shadow registers and rollover flags are zero, `bus_ready` is 1 and `bus_rvalid` is 0.
- R2: A high `ev_inc[k]` adds one to live counter k. For the octet lanes (index `RX_OCT_IDX`, `TX_OCT_IDX`) it adds the value on `rx_octets` / `tx_octets` instead. A byte count presented without its strobe has no effect.
- R3: An accepted write to address 0x00 with data bit 0 set copies every live counter into its shadow at that edge. A write with bit 0 clear, or a write to any other address, leaves the shadows unchanged.
- R4: An increment that arrives in the same cycle as a snapshot goes into the live counter but not into the shadow taken at that edge. A later snapshot shows it.
- R5: Shadow k is read at addresses 0x40+4k+n:
  - n=0 returns bits 15:0.
  - n=1 returns bits 31:16.
  - n=2 returns bits 39:32 in bits 7:0, with bits 15:8 zero.
  - n=3 reads zero.
- R6: The rollover vector is read at 0x04..0x07, with 16 bits per word and word 0 holding the lowest bits. Bit k belongs to counter k, so the bit index is the counter's address offset from 0x40 divided by 4. Bits of counters that do not exist read zero.
- R7: When live counter k passes from its maximum value through zero, rollover bit k becomes 1.
- R8: A read of a rollover word returns the word as it was, then clears its 16 bits. If a counter of that word wraps in the same cycle, its bit stays 1.
- R9: Reads of any register leave the live counters unchanged.
- R10: A read accepted while `bus_ready` is 1 gives `bus_rvalid`=1 with its data in the next cycle.
  - `bus_ready` is 0 in the cycle after any accepted read or snapshot.
  - Requests made while `bus_ready` is 0 are ignored.
  - When read and write are requested together, the read wins and the write is dropped.
- R11: Address 0x00 and every unmapped address read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_inc | input | NUM_CNT | One increment strobe per counter |
| rx_octets | input | BYTE_W | Byte count for the receive octet lane |
| tx_octets | input | BYTE_W | Byte count for the transmit octet lane |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data (bit 0 = snapshot) |
| bus_ready | output | 1 | Port can accept a request this cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 16 | Read data |

## Verification
A wrong internal state mostly shows up late and indirectly. Wrong counter state, such as a lost increment, a bad carry or a missed wrap, only appears after the next snapshot and a read of the affected window or rollover word. A shadow that captured too early or too late differs by exactly the increments of the snapshot cycle. A rollover bit that cleared in the same cycle as a wrap only shows on the second read of that word. A bus state machine stuck in the wrong state is different: it shows within one cycle as a wrong `bus_ready` or `bus_rvalid`. The bench therefore keeps a cycle-accurate reference model of every counter and flag, and compares each read against it.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

    // Register port word width and rollover vector geometry
    localparam int WORD_W     = 16;
    localparam int ROLL_WORDS = 4;
    localparam int ROLL_BITS  = WORD_W * ROLL_WORDS;

    // Fixed address map: control, rollover words, counter windows
    localparam int CTRL_ADDR  = 0;
    localparam int ROLL_ADDR  = 4;
    localparam int CNT_ADDR   = 64;
    localparam int CNT_STRIDE = 4;
    localparam int VIEW_W     = 48;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_OUT  = 2'd1,
        ST_SNAP_HOLD = 2'd2
    } bus_state_t;

endpackage

// File: rtl/stat_count_lane.sv
module stat_count_lane #(
    parameter int CNT_W = 40,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic [INC_W-1:0] amount_i,
    input  logic             snap_i,
    output logic [CNT_W-1:0] shadow_o,
    output logic             wrap_o
);

    localparam int PAD_W = CNT_W + 1 - INC_W;

    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum    = {1'b0, live_q} + {{PAD_W{1'b0}}, amount_i};
        wrap_o = inc_i & sum[CNT_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (inc_i) begin
                live_q <= sum[CNT_W-1:0];
            end
            if (snap_i) begin
                shadow_q <= live_q;
            end
        end
    end

    assign shadow_o = shadow_q;

    // The live value moves only on its own strobe (reads cannot touch it)
    assert_live_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(live_q));

    // A snapshot captures the value the live counter held before that edge
    assert_snap_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> (shadow_q == $past(live_q)));

    // Shadows never move without a snapshot
    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(shadow_q));

    // A wrap always lands below the previous value
    assert_wrap_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (live_q < $past(live_q)));

endmodule

// File: rtl/stat_rollover_flags.sv
module stat_rollover_flags
    import stat_bank_pkg::*;
#(
    parameter int NUM_CNT = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CNT-1:0]   wrap_i,
    input  logic                 clr_en_i,
    input  logic [1:0]           clr_sel_i,
    output logic [ROLL_BITS-1:0] flags_o
);

    logic [ROLL_BITS-1:0] wrap_full;
    logic [ROLL_BITS-1:0] clr_mask;
    logic [WORD_W-1:0]    word_q [ROLL_WORDS];

    always_comb begin
        wrap_full                = '0;
        wrap_full[NUM_CNT-1:0]   = wrap_i;
        clr_mask                 = '0;
        if (clr_en_i) begin
            clr_mask = {{(ROLL_BITS-WORD_W){1'b0}}, {WORD_W{1'b1}}}
                       << (WORD_W * int'(clr_sel_i));
        end
    end

    for (genvar w = 0; w < ROLL_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else begin
                // set wins over clear so a wrap in the read cycle survives
                word_q[w] <= (word_q[w] & ~clr_mask[w*WORD_W +: WORD_W])
                           | wrap_full[w*WORD_W +: WORD_W];
            end
        end
        assign flags_o[w*WORD_W +: WORD_W] = word_q[w];
    end

    assert_wrap_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_full) |=> ((flags_o & $past(wrap_full)) == $past(wrap_full)));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((flags_o & $past(clr_mask) & ~$past(wrap_full)) == '0));

endmodule

// File: rtl/stat_bus_fsm.sv
module stat_bus_fsm
    import stat_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              snap_bit_i,
    output logic              rd_accept_o,
    output logic              snap_o,
    output logic              ready_o,
    output logic              rvalid_o
);

    bus_state_t state_q;
    bus_state_t state_d;
    logic       is_ctrl;

    assign is_ctrl = (bus_addr_i == ADDR_W'(CTRL_ADDR));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_rd_i) begin
                    state_d = ST_READ_OUT;
                end else if (bus_wr_i && is_ctrl && snap_bit_i) begin
                    state_d = ST_SNAP_HOLD;
                end
            end
            ST_READ_OUT:  state_d = ST_IDLE;
            ST_SNAP_HOLD: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready_o     = 1'b0;
        rvalid_o    = 1'b0;
        rd_accept_o = 1'b0;
        snap_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o     = 1'b1;
                rd_accept_o = bus_rd_i;
                snap_o      = !bus_rd_i && bus_wr_i && is_ctrl && snap_bit_i;
            end
            ST_READ_OUT:  rvalid_o = 1'b1;
            ST_SNAP_HOLD: ready_o  = 1'b0;
            default:      ready_o  = 1'b0;
        endcase
    end

    assert_rvalid_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept_o |=> (rvalid_o && !ready_o));

    assert_busy_after_snap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snap_o |=> (!ready_o && !rvalid_o));

    assert_rvalid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o);

    assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (!rd_accept_o && !snap_o));

endmodule

// File: rtl/stat_read_mux.sv
module stat_read_mux
    import stat_bank_pkg::*;
#(
    parameter int NUM_CNT = 20,
    parameter int CNT_W   = 40,
    parameter int ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [NUM_CNT*CNT_W-1:0] shadow_flat_i,
    input  logic [ROLL_BITS-1:0]     flags_i,
    output logic [WORD_W-1:0]        rdata_o,
    output logic                     roll_hit_o
);

    localparam int SEL_W = ADDR_W - 2;

    logic [ADDR_W-1:0] off;
    logic [SEL_W-1:0]  sel;
    logic              in_cnt;
    logic [VIEW_W-1:0] view;

    always_comb begin
        off        = addr_i - ADDR_W'(CNT_ADDR);
        sel        = off[ADDR_W-1:2];
        roll_hit_o = (addr_i[ADDR_W-1:2] == SEL_W'(ROLL_ADDR / 4));
        in_cnt     = (addr_i >= ADDR_W'(CNT_ADDR)) && (int'(sel) < NUM_CNT);
        view       = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (sel == SEL_W'(k)) begin
                view[CNT_W-1:0] = shadow_flat_i[k*CNT_W +: CNT_W];
            end
        end
        rdata_o = '0;
        if (roll_hit_o) begin
            rdata_o = flags_i[WORD_W*int'(addr_i[1:0]) +: WORD_W];
        end else if (in_cnt) begin
            unique case (addr_i[1:0])
                2'd0:    rdata_o = view[15:0];
                2'd1:    rdata_o = view[31:16];
                2'd2:    rdata_o = view[47:32];
                default: rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/stat_snapshot_bank.sv
module stat_snapshot_bank
    import stat_bank_pkg::*;
#(
    parameter int NUM_CNT    = 20,
    parameter int CNT_W      = 40,
    parameter int BYTE_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int RX_OCT_IDX = 0,
    parameter int TX_OCT_IDX = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] ev_inc,
    input  logic [BYTE_W-1:0]  rx_octets,
    input  logic [BYTE_W-1:0]  tx_octets,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic               bus_ready,
    output logic               bus_rvalid,
    output logic [15:0]        bus_rdata
);

    logic [NUM_CNT*CNT_W-1:0] shadow_flat;
    logic [NUM_CNT-1:0]       wrap_vec;
    logic [ROLL_BITS-1:0]     flags;
    logic [WORD_W-1:0]        mux_data;
    logic                     roll_hit;
    logic                     rd_accept;
    logic                     snap;
    logic [WORD_W-1:0]        rdata_q;
    logic                     unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata[15:1];

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_lane
        if (k == RX_OCT_IDX) begin : g_rx_oct
            stat_count_lane #(.CNT_W(CNT_W), .INC_W(BYTE_W)) u_lane (
                .clk(clk), .rst_n(rst_n), .inc_i(ev_inc[k]),
                .amount_i(rx_octets), .snap_i(snap),
                .shadow_o(shadow_flat[k*CNT_W +: CNT_W]), .wrap_o(wrap_vec[k]));
        end else if (k == TX_OCT_IDX) begin : g_tx_oct
            stat_count_lane #(.CNT_W(CNT_W), .INC_W(BYTE_W)) u_lane (
                .clk(clk), .rst_n(rst_n), .inc_i(ev_inc[k]),
                .amount_i(tx_octets), .snap_i(snap),
                .shadow_o(shadow_flat[k*CNT_W +: CNT_W]), .wrap_o(wrap_vec[k]));
        end else begin : g_frame
            stat_count_lane #(.CNT_W(CNT_W), .INC_W(1)) u_lane (
                .clk(clk), .rst_n(rst_n), .inc_i(ev_inc[k]),
                .amount_i(1'b1), .snap_i(snap),
                .shadow_o(shadow_flat[k*CNT_W +: CNT_W]), .wrap_o(wrap_vec[k]));
        end
    end

    stat_rollover_flags #(.NUM_CNT(NUM_CNT)) u_roll (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap_vec),
        .clr_en_i(rd_accept && roll_hit), .clr_sel_i(bus_addr[1:0]),
        .flags_o(flags));

    stat_read_mux #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_mux (
        .addr_i(bus_addr), .shadow_flat_i(shadow_flat), .flags_i(flags),
        .rdata_o(mux_data), .roll_hit_o(roll_hit));

    stat_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_rd_i(bus_rd), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .snap_bit_i(bus_wdata[0]),
        .rd_accept_o(rd_accept), .snap_o(snap),
        .ready_o(bus_ready), .rvalid_o(bus_rvalid));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_accept) begin
            rdata_q <= mux_data;
        end
    end

    assign bus_rdata = rdata_q;

    // returned data stays put while no read is being presented
    assert_rdata_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_accept) |-> $stable(bus_rdata));

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (bus_ready && !bus_rvalid));

endmodule

// File: tb/stat_snapshot_bank_bench.sv
module stat_snapshot_bank_bench;

    localparam int N = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] ev_inc = '0;
    logic [15:0] rx_octets = '0;
    logic [15:0] tx_octets = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        ready_w, rvalid_w, ready_n, rvalid_n;
    logic [15:0] rdata_w, rdata_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    stat_snapshot_bank u_stat_snapshot_bank (
        .clk(clk), .rst_n(rst_n), .ev_inc(ev_inc), .rx_octets(rx_octets),
        .tx_octets(tx_octets), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(ready_w),
        .bus_rvalid(rvalid_w), .bus_rdata(rdata_w));

    // narrow copy so that wraps happen in reachable time
    stat_snapshot_bank #(.CNT_W(16)) u_stat_snapshot_bank_narrow (
        .clk(clk), .rst_n(rst_n), .ev_inc(ev_inc), .rx_octets(rx_octets),
        .tx_octets(tx_octets), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(ready_n),
        .bus_rvalid(rvalid_n), .bus_rdata(rdata_n));

    // reference model, index 0 = 40-bit instance, 1 = 16-bit instance
    longint    m_live   [2][N];
    longint    m_shadow [2][N];
    bit [63:0] m_roll   [2];
    bit        busy = 1'b0;
    bit        pend = 1'b0;
    string     pend_tag;
    logic [15:0] exp_w, exp_n;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input int i, input int a);
        longint v;
        if (a >= 4 && a < 8) return m_roll[i][16*(a-4) +: 16];
        if (a >= 64 && a < 64 + 4*N) begin
            v = m_shadow[i][(a-64)/4];
            case (a % 4)
                0: return v[15:0];
                1: return v[31:16];
                2: return v[47:32];
                default: return 16'h0;
            endcase
        end
        return 16'h0;
    endfunction

    task automatic model_update(input int i, input logic [N-1:0] inc,
                                input logic [15:0] rxb, input logic [15:0] txb,
                                input bit acc_rd, input bit acc_wr, input int a);
        longint lim, n, amt;
        bit [63:0] wraps = '0;
        lim = (i == 0) ? (longint'(1) << 40) : (longint'(1) << 16);
        for (int k = 0; k < N; k++) begin
            if (acc_wr) m_shadow[i][k] = m_live[i][k];
            if (inc[k]) begin
                amt = (k == 0) ? longint'(rxb) : (k == 13) ? longint'(txb) : 1;
                n = m_live[i][k] + amt;
                if (n >= lim) begin n -= lim; wraps[k] = 1'b1; end
                m_live[i][k] = n;
            end
        end
        if (acc_rd && a >= 4 && a < 8) m_roll[i] &= ~(64'hFFFF << (16*(a-4)));
        m_roll[i] |= wraps;
    endtask

    task automatic step(input logic [N-1:0] inc, input logic [15:0] rxb,
                        input logic [15:0] txb, input logic rd, input logic wr,
                        input logic [7:0] a, input logic [15:0] wd, input string tag);
        bit acc_rd, acc_wr;
        @(negedge clk);
        if (pend) begin
            chk({pend_tag, " R10 rvalid"}, 64'(rvalid_w & rvalid_n), 64'd1);
            chk({pend_tag, " wide"}, 64'(rdata_w), 64'(exp_w));
            chk({pend_tag, " narrow"}, 64'(rdata_n), 64'(exp_n));
            pend = 1'b0;
        end
        if (rd || wr) chk("R10 ready", 64'({ready_w, ready_n}), busy ? 64'd0 : 64'd3);
        ev_inc = inc; rx_octets = rxb; tx_octets = txb;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        acc_rd = rd && !busy;
        acc_wr = wr && !rd && !busy && (a == 8'h00) && wd[0];
        if (acc_rd) begin
            exp_w = exp_read(0, int'(a));
            exp_n = exp_read(1, int'(a));
            pend = 1'b1;
            pend_tag = tag;
        end
        for (int i = 0; i < 2; i++) model_update(i, inc, rxb, txb, acc_rd, acc_wr, int'(a));
        busy = acc_rd || acc_wr;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) step('0, 16'd0, 16'd0, 1'b0, 1'b0, 8'h00, 16'h0, "idle");
    endtask

    task automatic rd_reg(input logic [7:0] a, input string tag);
        step('0, 16'd0, 16'd0, 1'b1, 1'b0, a, 16'h0, tag);
        idle(1);
    endtask

    task automatic take_snap();
        step('0, 16'd0, 16'd0, 1'b0, 1'b1, 8'h00, 16'h0001, "R3 snap");
        idle(1);
    endtask

    task automatic read_all(input string tag);
        for (int k = 0; k < N; k++)
            for (int f = 0; f < 4; f++) rd_reg(8'(64 + 4*k + f), tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ready", 64'({ready_w, ready_n}), 64'd3);
        chk("R1 rvalid", 64'({rvalid_w, rvalid_n}), 64'd0);
        take_snap();
        read_all("R1 zero counters");
        for (int w = 0; w < 4; w++) rd_reg(8'(4 + w), "R1 zero rollover");
    endtask

    task automatic t_increments();
        // byte counts without strobe must be ignored
        step('0, 16'd900, 16'd700, 1'b0, 1'b0, 8'h00, 16'h0, "R2");
        step(20'h00001, 16'd64, 16'd0, 1'b0, 1'b0, 8'h00, 16'h0, "R2");
        step(20'h02000, 16'd5, 16'd1500, 1'b0, 1'b0, 8'h00, 16'h0, "R2");
        step(20'hAAAAA, 16'd1518, 16'd60, 1'b0, 1'b0, 8'h00, 16'h0, "R2");
        step(20'h55555, 16'd3, 16'd9, 1'b0, 1'b0, 8'h00, 16'h0, "R2");
        step(20'hFFFFF, 16'd65535, 16'd65535, 1'b0, 1'b0, 8'h00, 16'h0, "R2");
        take_snap();
        read_all("R2 R5 counts");
    endtask

    task automatic t_snap_collision();
        step(20'hFFFFF, 16'd100, 16'd200, 1'b0, 1'b1, 8'h00, 16'h0001, "R4");
        idle(1);
        read_all("R4 shadow excludes same-cycle");
        take_snap();
        read_all("R4 later snapshot includes");
    endtask

    task automatic t_no_snap();
        step(20'h0F0F0, 16'd0, 16'd0, 1'b0, 1'b0, 8'h00, 16'h0, "R3");
        step('0, 16'd0, 16'd0, 1'b0, 1'b1, 8'h00, 16'h0002, "R3 bit0 clear");
        idle(1);
        step('0, 16'd0, 16'd0, 1'b0, 1'b1, 8'h44, 16'h0001, "R3 other addr");
        idle(1);
        for (int k = 4; k < 8; k++) rd_reg(8'(64 + 4*k), "R3 shadow unchanged");
    endtask

    task automatic t_map();
        rd_reg(8'h00, "R11 control");
        rd_reg(8'h02, "R11 gap");
        rd_reg(8'h20, "R11 gap");
        rd_reg(8'h90, "R11 beyond counters");
        rd_reg(8'hFF, "R11 top");
        rd_reg(8'h43, "R5 fourth word");
    endtask

    task automatic t_busy();
        step(20'h00002, 16'd0, 16'd0, 1'b1, 1'b0, 8'h44, 16'h0, "R10 read");
        // request while busy: must be ignored
        step(20'h00002, 16'd0, 16'd0, 1'b0, 1'b1, 8'h00, 16'h0001, "R10 busy");
        idle(1);
        rd_reg(8'h44, "R10 ignored snapshot");
        // read and snapshot write together: read wins
        step(20'h00002, 16'd0, 16'd0, 1'b1, 1'b1, 8'h00, 16'h0001, "R10 rd wins");
        idle(1);
        rd_reg(8'h44, "R10 write dropped");
        take_snap();
        rd_reg(8'h44, "R9 reads left live intact");
        rd_reg(8'h40, "R9 reads left live intact");
    endtask

    task automatic t_long_run();
        for (int c = 0; c < 65600; c++)
            step(20'hFFFFF, 16'd65535, 16'd65535, 1'b0, 1'b0, 8'h00, 16'h0, "R7");
        take_snap();
        rd_reg(8'h42, "R5 bits 39:32");
        rd_reg(8'h41, "R5 bits 31:16");
        rd_reg(8'h40, "R5 bits 15:0");
        rd_reg(8'h5A, "R5 frame counter upper");
        for (int w = 0; w < 4; w++) rd_reg(8'(4 + w), "R7 R6 rollover set");
        for (int w = 0; w < 4; w++) rd_reg(8'(4 + w), "R8 cleared after read");
    endtask

    task automatic t_clear_collision();
        longint v;
        step(20'h00001, 16'd7, 16'd0, 1'b0, 1'b0, 8'h00, 16'h0, "R8");
        v = m_live[1][0];
        // read word 0 exactly as the narrow receive octet counter wraps
        step(20'h00001, 16'(65536 - v), 16'd0, 1'b1, 1'b0, 8'h04, 16'h0, "R8 collide");
        idle(1);
        rd_reg(8'h04, "R8 bit survives clear");
        rd_reg(8'h04, "R8 bit cleared next");
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_roll[i] = '0;
            for (int k = 0; k < N; k++) begin m_live[i][k] = 0; m_shadow[i][k] = 0; end
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_increments();
        t_snap_collision();
        t_no_snap();
        t_map();
        t_busy();
        t_long_run();
        t_clear_collision();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule